// File: doc/BRIEF.md
# ECC Error Injection and Single-Bit Threshold Monitor

This block sits beside the data path of a memory controller that protects its data with an ECC code. On the write side it can corrupt outgoing beats on purpose, so that diagnostic software can exercise the ECC logic. While injection is on, every write beat is XORed with a programmable 64-bit corruption mask. A mask with one bit set gives a correctable error, and a mask with several bits set gives an uncorrectable one. While injection is off, beats pass through unchanged.

On the read side, an external ECC decoder reports each beat with a single-bit pulse or a multi-bit pulse. The block counts single-bit reports in an 8-bit counter. When the counter reaches a programmable threshold, it raises a sticky flag and the counter returns to zero. Multi-bit reports are only flagged. A further sticky flag records that an error condition occurred again while its flag was already set. The block also captures the data of the last reported beat together with the kind of error.

Software works through a simple word-wide register port. It sets the mask halves, the threshold and the injection enable. It can load the counter directly, and it reads back and clears the flags.

Top module: `ecc_inject_mon`

## Requirements
- R1: After reset, every readable register reads zero: injection is off, both mask words are 0, the threshold is 0, the counter is 0, all flags are clear and the capture kind is 0.
- R2: While the enable (address 0x0, bit 0) is 0, wr_beat_data_o equals wr_beat_data_i whatever the mask holds, and wr_beat_valid_o always follows wr_beat_valid_i.
- R3: While the enable is 1, wr_beat_data_o equals wr_beat_data_i XOR {mask_hi, mask_lo}. The word at address 0x1 drives bits 63:32 and the word at address 0x2 drives bits 31:0.
- R4: Each clock cycle with rd_sbe_i high adds one to the counter (address 0x4, bits 7:0). The single-bit flag stays clear while the count stays below the threshold (address 0x3, bits 7:0).
- R5: With a non-zero threshold, the report that would bring the counter to the threshold sets the single-bit flag (address 0x5, bit 0) and leaves the counter at 0, both at the same edge.
- R6: With the threshold at 0, the counter stops at 255 and the single-bit flag is never set.
- R7: A cycle with rd_mbe_i high sets the multi-bit flag (address 0x5, bit 1). Nothing is corrected.
- R8: The repeat flag (address 0x5, bit 2) is set when the threshold is reached while the single-bit flag is already set, or when a multi-bit report arrives while the multi-bit flag is already set.
- R9: The flags are sticky. A write to address 0x5 clears each flag whose bit in the write data is 1, and in that cycle no new report sets any flag.
- R10: A write to address 0x4 loads the counter. Such a write takes precedence over a single-bit report in the same cycle, and that report is then neither counted nor compared.
- R11: Every report loads rd_beat_data_i into the capture registers (0x6 high word, 0x7 low word) and loads the kind into address 0x8: 1 for single-bit, 2 for multi-bit. When both pulses arrive in the same cycle, the kind is 2.
- R12: reg_rdata shows the register selected by reg_addr in the same cycle, and unused bits and addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address for writes and reads |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| wr_beat_valid_i | input | 1 | Write beat valid from the controller |
| wr_beat_data_i | input | 64 | Write beat data from the controller |
| wr_beat_valid_o | output | 1 | Write beat valid towards the ECC encoder |
| wr_beat_data_o | output | 64 | Write beat data, corrupted when enabled |
| rd_beat_data_i | input | 64 | Read beat data that comes with the decoder reports |
| rd_sbe_i | input | 1 | Single-bit error report for this beat |
| rd_mbe_i | input | 1 | Multi-bit error report for this beat |

## Verification
Properties are checked on every cycle for the following: pass-through while injection is off, the number of flipped bits equal to the mask weight while it is on, flags that stay set unless a clear is written, the multi-bit flag after a report, a counter at zero whenever the single-bit flag rises, and saturation with no flag under a zero threshold. Other behaviour only shows up in the bench scenarios. This covers the exact count sequence up to a threshold, the setting of the repeat flag on a second occurrence, a clear that swallows an event in the same cycle, a counter write beating a report in the same cycle, and the priority of the capture kind. A behavioural model follows every register and the write path cycle by cycle.

// File: rtl/eim_pkg.sv
package eim_pkg;

  localparam int REG_W  = 32;
  localparam int ADDR_W = 4;
  localparam int FLAG_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL     = 4'h0,
    A_MASK_HI  = 4'h1,
    A_MASK_LO  = 4'h2,
    A_THR      = 4'h3,
    A_CNT      = 4'h4,
    A_DET      = 4'h5,
    A_CAP_HI   = 4'h6,
    A_CAP_LO   = 4'h7,
    A_CAP_KIND = 4'h8
  } reg_addr_e;

  typedef enum logic [1:0] {
    CAP_NONE = 2'd0,
    CAP_SBE  = 2'd1,
    CAP_MBE  = 2'd2
  } cap_kind_e;

  typedef struct packed {
    logic multi;
    logic mbe;
    logic sbe;
  } det_flags_t;

endpackage

// File: rtl/eim_regs.sv
module eim_regs
  import eim_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int CNT_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [REG_W-1:0]   reg_wdata,
  output logic [REG_W-1:0]   reg_rdata,
  output logic               inj_en,
  output logic [DATA_W-1:0]  inj_mask,
  output logic [CNT_W-1:0]   sbe_thr,
  output logic               cnt_we,
  output logic [CNT_W-1:0]   cnt_wval,
  output logic               det_clr_we,
  output logic [FLAG_W-1:0]  det_clr_bits,
  input  logic [CNT_W-1:0]   sbe_cnt,
  input  det_flags_t         det_flags,
  input  logic [DATA_W-1:0]  cap_data,
  input  cap_kind_e          cap_kind
);

  localparam int N_WORDS = DATA_W / REG_W;
  localparam int PAD_CNT = REG_W - CNT_W;
  localparam int PAD_FLG = REG_W - FLAG_W;
  localparam int PAD_KND = REG_W - 2;

  logic                sel_ctrl, sel_hi, sel_lo, sel_thr;
  logic                inj_en_d;
  logic [REG_W-1:0]    mask_hi_q, mask_lo_q, mask_hi_d, mask_lo_d;
  logic [CNT_W-1:0]    thr_d;

  always_comb begin
    sel_ctrl = reg_we && (reg_addr == A_CTRL);
    sel_hi   = reg_we && (reg_addr == A_MASK_HI);
    sel_lo   = reg_we && (reg_addr == A_MASK_LO);
    sel_thr  = reg_we && (reg_addr == A_THR);
    inj_en_d  = sel_ctrl ? reg_wdata[0]          : inj_en;
    mask_hi_d = sel_hi   ? reg_wdata             : mask_hi_q;
    mask_lo_d = sel_lo   ? reg_wdata             : mask_lo_q;
    thr_d     = sel_thr  ? reg_wdata[CNT_W-1:0]  : sbe_thr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inj_en    <= 1'b0;
      mask_hi_q <= '0;
      mask_lo_q <= '0;
      sbe_thr   <= '0;
    end else begin
      inj_en    <= inj_en_d;
      mask_hi_q <= mask_hi_d;
      mask_lo_q <= mask_lo_d;
      sbe_thr   <= thr_d;
    end
  end

  assign inj_mask     = {mask_hi_q, mask_lo_q};
  assign cnt_we       = reg_we && (reg_addr == A_CNT);
  assign cnt_wval     = reg_wdata[CNT_W-1:0];
  assign det_clr_we   = reg_we && (reg_addr == A_DET);
  assign det_clr_bits = reg_wdata[FLAG_W-1:0];

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL:     reg_rdata = {{(REG_W-1){1'b0}}, inj_en};
      A_MASK_HI:  reg_rdata = mask_hi_q;
      A_MASK_LO:  reg_rdata = mask_lo_q;
      A_THR:      reg_rdata = {{PAD_CNT{1'b0}}, sbe_thr};
      A_CNT:      reg_rdata = {{PAD_CNT{1'b0}}, sbe_cnt};
      A_DET:      reg_rdata = {{PAD_FLG{1'b0}}, det_flags};
      A_CAP_HI:   reg_rdata = cap_data[(N_WORDS*REG_W)-1 -: REG_W];
      A_CAP_LO:   reg_rdata = cap_data[REG_W-1:0];
      A_CAP_KIND: reg_rdata = {{PAD_KND{1'b0}}, cap_kind};
      default:    reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/eim_inject.sv
module eim_inject
  import eim_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              inj_en,
  input  logic [DATA_W-1:0] inj_mask,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o
);

  localparam int N_WORDS = DATA_W / REG_W;

  for (genvar w = 0; w < N_WORDS; w++) begin : g_word
    logic [REG_W-1:0] flip;
    assign flip = inj_en ? inj_mask[w*REG_W +: REG_W] : '0;
    assign data_o[w*REG_W +: REG_W] = data_i[w*REG_W +: REG_W] ^ flip;
  end

  assign valid_o = valid_i;

endmodule

// File: rtl/eim_sbe_counter.sv
module eim_sbe_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sbe_i,
  input  logic [CNT_W-1:0] thr,
  input  logic             sw_we,
  input  logic [CNT_W-1:0] sw_val,
  output logic [CNT_W-1:0] cnt,
  output logic             thr_hit
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_inc, cnt_d;
  logic             thr_off, cnt_en;

  always_comb begin
    cnt_inc = cnt + 1'b1;
    thr_off = (thr == '0);
    thr_hit = 1'b0;
    cnt_en  = sw_we || sbe_i;
    cnt_d   = cnt;
    if (sw_we) begin
      cnt_d = sw_val;
    end else if (sbe_i) begin
      if (thr_off) begin
        cnt_d = (cnt == CNT_MAX) ? CNT_MAX : cnt_inc;
      end else if (cnt_inc == thr) begin
        cnt_d   = '0;
        thr_hit = 1'b1;
      end else begin
        cnt_d = cnt_inc;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (cnt_en) begin
      cnt <= cnt_d;
    end
  end

endmodule

// File: rtl/eim_detect.sv
module eim_detect
  import eim_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              thr_hit,
  input  logic              sbe_i,
  input  logic              mbe_i,
  input  logic [DATA_W-1:0] rd_data_i,
  input  logic              clr_we,
  input  logic [FLAG_W-1:0] clr_bits,
  output det_flags_t        flags,
  output logic [DATA_W-1:0] cap_data,
  output cap_kind_e         cap_kind
);

  det_flags_t  flags_d;
  logic        cap_en;
  cap_kind_e   kind_d;

  always_comb begin
    flags_d = flags;
    if (clr_we) begin
      flags_d = flags & ~det_flags_t'(clr_bits);
    end else begin
      if (thr_hit) begin
        flags_d.sbe = 1'b1;
        if (flags.sbe) flags_d.multi = 1'b1;
      end
      if (mbe_i) begin
        flags_d.mbe = 1'b1;
        if (flags.mbe) flags_d.multi = 1'b1;
      end
    end
  end

  always_comb begin
    cap_en = sbe_i || mbe_i;
    kind_d = mbe_i ? CAP_MBE : CAP_SBE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
    end else begin
      flags <= flags_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_data <= '0;
      cap_kind <= CAP_NONE;
    end else if (cap_en) begin
      cap_data <= rd_data_i;
      cap_kind <= kind_d;
    end
  end

endmodule

// File: rtl/ecc_inject_mon.sv
module ecc_inject_mon
  import eim_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    reg_we,
  input  logic [ADDR_W-1:0]       reg_addr,
  input  logic [REG_W-1:0]        reg_wdata,
  output logic [REG_W-1:0]        reg_rdata,
  input  logic                    wr_beat_valid_i,
  input  logic [2*REG_W-1:0]      wr_beat_data_i,
  output logic                    wr_beat_valid_o,
  output logic [2*REG_W-1:0]      wr_beat_data_o,
  input  logic [2*REG_W-1:0]      rd_beat_data_i,
  input  logic                    rd_sbe_i,
  input  logic                    rd_mbe_i
);

  localparam int DATA_W = 2 * REG_W;

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              inj_en;
  logic [DATA_W-1:0] inj_mask;
  logic [CNT_W-1:0]  sbe_thr, sbe_cnt, cnt_wval;
  logic              cnt_we, thr_hit, det_clr_we;
  logic [FLAG_W-1:0] det_clr_bits;
  det_flags_t        det_flags;
  logic [DATA_W-1:0] cap_data;
  cap_kind_e         cap_kind;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  eim_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .reg_we       (reg_we),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .inj_en       (inj_en),
    .inj_mask     (inj_mask),
    .sbe_thr      (sbe_thr),
    .cnt_we       (cnt_we),
    .cnt_wval     (cnt_wval),
    .det_clr_we   (det_clr_we),
    .det_clr_bits (det_clr_bits),
    .sbe_cnt      (sbe_cnt),
    .det_flags    (det_flags),
    .cap_data     (cap_data),
    .cap_kind     (cap_kind)
  );

  eim_inject #(.DATA_W(DATA_W)) u_inject (
    .inj_en   (inj_en),
    .inj_mask (inj_mask),
    .valid_i  (wr_beat_valid_i),
    .data_i   (wr_beat_data_i),
    .valid_o  (wr_beat_valid_o),
    .data_o   (wr_beat_data_o)
  );

  eim_sbe_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .sbe_i   (rd_sbe_i),
    .thr     (sbe_thr),
    .sw_we   (cnt_we),
    .sw_val  (cnt_wval),
    .cnt     (sbe_cnt),
    .thr_hit (thr_hit)
  );

  eim_detect #(.DATA_W(DATA_W)) u_det (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .thr_hit   (thr_hit),
    .sbe_i     (rd_sbe_i),
    .mbe_i     (rd_mbe_i),
    .rd_data_i (rd_beat_data_i),
    .clr_we    (det_clr_we),
    .clr_bits  (det_clr_bits),
    .flags     (det_flags),
    .cap_data  (cap_data),
    .cap_kind  (cap_kind)
  );

endmodule

// File: rtl/eim_checker.sv
module eim_checker #(
  parameter int DATA_W = 64,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rst_int_n,
  input logic              inj_en,
  input logic [DATA_W-1:0] inj_mask,
  input logic              wr_beat_valid_i,
  input logic              wr_beat_valid_o,
  input logic [DATA_W-1:0] wr_beat_data_i,
  input logic [DATA_W-1:0] wr_beat_data_o,
  input logic              rd_sbe_i,
  input logic              rd_mbe_i,
  input logic              cnt_we,
  input logic              det_clr_we,
  input logic [CNT_W-1:0]  sbe_thr,
  input logic [CNT_W-1:0]  sbe_cnt,
  input logic [2:0]        det_flags
);

  localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

  always_comb begin
    if (rst_int_n && !inj_en) begin
      AST_PASS_WHEN_OFF: assert (wr_beat_data_o == wr_beat_data_i); // R2
    end
    if (rst_int_n) begin
      AST_VALID_FOLLOWS: assert (wr_beat_valid_o == wr_beat_valid_i); // R2
    end
    if (rst_int_n && inj_en) begin
      AST_FLIP_WEIGHT: assert ($countones(wr_beat_data_o ^ wr_beat_data_i) == $countones(inj_mask)); // R3
    end
  end

  AST_MBE_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rd_mbe_i && !det_clr_we) |=> det_flags[1]); // R7

  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(det_flags[0]) |-> (sbe_cnt == '0)); // R5

  AST_ZERO_THR_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_int_n)
    ((sbe_thr == '0) && !det_flags[0]) |=> !det_flags[0]); // R6

  AST_ZERO_THR_SATURATE: assert property (@(posedge clk) disable iff (!rst_int_n)
    ((sbe_thr == '0) && (sbe_cnt == CNT_TOP) && rd_sbe_i && !cnt_we) |=> (sbe_cnt == CNT_TOP)); // R6

  AST_SBE_STICKY: assert property (@(posedge clk) disable iff (!rst_int_n)
    (det_flags[0] && !det_clr_we) |=> det_flags[0]); // R9

  AST_MULTI_STICKY: assert property (@(posedge clk) disable iff (!rst_int_n)
    (det_flags[2] && !det_clr_we) |=> det_flags[2]); // R9

endmodule

bind ecc_inject_mon eim_checker #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk             (clk),
  .rst_int_n       (rst_int_n),
  .inj_en          (inj_en),
  .inj_mask        (inj_mask),
  .wr_beat_valid_i (wr_beat_valid_i),
  .wr_beat_valid_o (wr_beat_valid_o),
  .wr_beat_data_i  (wr_beat_data_i),
  .wr_beat_data_o  (wr_beat_data_o),
  .rd_sbe_i        (rd_sbe_i),
  .rd_mbe_i        (rd_mbe_i),
  .cnt_we          (cnt_we),
  .det_clr_we      (det_clr_we),
  .sbe_thr         (sbe_thr),
  .sbe_cnt         (sbe_cnt),
  .det_flags       (det_flags)
);

// File: tb/ecc_inject_mon_tb.sv
`timescale 1ns/1ps
module ecc_inject_mon_tb;

  logic        clk;
  logic        rst_n;
  logic        reg_we;
  logic [3:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        wr_beat_valid_i, wr_beat_valid_o;
  logic [63:0] wr_beat_data_i, wr_beat_data_o;
  logic [63:0] rd_beat_data_i;
  logic        rd_sbe_i, rd_mbe_i;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  ecc_inject_mon u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .wr_beat_valid_i(wr_beat_valid_i), .wr_beat_data_i(wr_beat_data_i),
    .wr_beat_valid_o(wr_beat_valid_o), .wr_beat_data_o(wr_beat_data_o),
    .rd_beat_data_i(rd_beat_data_i), .rd_sbe_i(rd_sbe_i), .rd_mbe_i(rd_mbe_i)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // behavioural reference state
  bit          m_en;
  logic [31:0] m_hi, m_lo;
  int          m_thr, m_cnt;
  bit          m_sf, m_mf, m_xf;
  logic [63:0] m_cap;
  int          m_kind;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_hi = 0; m_lo = 0; m_thr = 0; m_cnt = 0;
      m_sf = 0; m_mf = 0; m_xf = 0; m_cap = 0; m_kind = 0;
    end else begin
      bit hit;
      int nc;
      hit = 0;
      nc  = m_cnt;
      if (reg_we && reg_addr == 4'h4) nc = reg_wdata[7:0];
      else if (rd_sbe_i) begin
        if (m_thr == 0) nc = (m_cnt == 255) ? 255 : m_cnt + 1;
        else if (((m_cnt + 1) % 256) == m_thr) begin nc = 0; hit = 1; end
        else nc = (m_cnt + 1) % 256;
      end
      if (reg_we && reg_addr == 4'h5) begin
        if (reg_wdata[0]) m_sf = 0;
        if (reg_wdata[1]) m_mf = 0;
        if (reg_wdata[2]) m_xf = 0;
      end else begin
        if (hit)      begin if (m_sf) m_xf = 1; m_sf = 1; end
        if (rd_mbe_i) begin if (m_mf) m_xf = 1; m_mf = 1; end
      end
      if (rd_sbe_i || rd_mbe_i) begin m_cap = rd_beat_data_i; m_kind = rd_mbe_i ? 2 : 1; end
      if (reg_we) begin
        case (reg_addr)
          4'h0: m_en  = reg_wdata[0];
          4'h1: m_hi  = reg_wdata;
          4'h2: m_lo  = reg_wdata;
          4'h3: m_thr = reg_wdata[7:0];
          default: ;
        endcase
      end
      m_cnt = nc;
    end
  end

  function automatic logic [31:0] model_rd(input logic [3:0] a);
    case (a)
      4'h0: return {31'b0, m_en};
      4'h1: return m_hi;
      4'h2: return m_lo;
      4'h3: return m_thr;
      4'h4: return m_cnt;
      4'h5: return {29'b0, m_xf, m_mf, m_sf};
      4'h6: return m_cap[63:32];
      4'h7: return m_cap[31:0];
      4'h8: return m_kind;
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R12 readback", {32'b0, reg_rdata}, {32'b0, model_rd(reg_addr)});
      check("R3 write path", wr_beat_data_o,
            wr_beat_data_i ^ (m_en ? {m_hi, m_lo} : 64'h0));
      check("R2 valid", {63'b0, wr_beat_valid_o}, {63'b0, wr_beat_valid_i});
    end
  end

  task automatic cyc(input bit we, input logic [3:0] a, input logic [31:0] wd,
                     input bit sbe, input bit mbe, input logic [63:0] rdd);
    @(negedge clk); #0.5;
    reg_we = we; reg_addr = a; reg_wdata = wd;
    rd_sbe_i = sbe; rd_mbe_i = mbe; rd_beat_data_i = rdd;
    @(negedge clk); #0.5;
    reg_we = 0; rd_sbe_i = 0; rd_mbe_i = 0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    cyc(1, a, d, 0, 0, 64'h0);
  endtask

  task automatic sbe(input int n);
    for (int i = 0; i < n; i++) cyc(0, 4'h0, 0, 1, 0, 64'h0);
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); #0.5;
    reg_addr = a;
    #0.5 d = reg_rdata;
  endtask

  task automatic beat(input logic [63:0] d, output logic [63:0] q);
    @(negedge clk); #0.5;
    wr_beat_valid_i = 1; wr_beat_data_i = d;
    #0.5 q = wr_beat_data_o;
    @(negedge clk); #0.5 wr_beat_valid_i = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [63:0] q;
    rst_n = 0; reg_we = 0; reg_addr = 0; reg_wdata = 0;
    wr_beat_valid_i = 0; wr_beat_data_i = 0; rd_beat_data_i = 0;
    rd_sbe_i = 0; rd_mbe_i = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (3) @(posedge clk);

    // R1 reset state
    for (int a = 0; a <= 8; a++) begin
      rd(a[3:0], r);
      check("R1 reset reg", {32'b0, r}, 64'h0);
    end
    rd(4'hA, r); check("R12 unused addr", {32'b0, r}, 64'h0);

    // R2 pass-through while disabled
    wr(4'h1, 32'h0000_0001);
    wr(4'h2, 32'h0000_0006);
    beat(64'h1234_5678_9ABC_DEF0, q);
    check("R2 disabled passthrough", q, 64'h1234_5678_9ABC_DEF0);

    // R3 injection on
    wr(4'h0, 32'h1);
    beat(64'h1234_5678_9ABC_DEF0, q);
    check("R3 mask xor", q, 64'h1234_5679_9ABC_DEF6);
    wr(4'h1, 32'h8000_0000);
    wr(4'h2, 32'h0);
    beat(64'hFFFF_FFFF_0000_0000, q);
    check("R3 hi word bit63", q, 64'h7FFF_FFFF_0000_0000);
    wr(4'h0, 32'h0);
    beat(64'hA5A5_A5A5_5A5A_5A5A, q);
    check("R2 disabled again", q, 64'hA5A5_A5A5_5A5A_5A5A);

    // R4/R5/R8 threshold counting
    wr(4'h3, 32'd5);
    sbe(3);
    rd(4'h4, r); check("R4 count below thr", {32'b0, r}, 64'd3);
    rd(4'h5, r); check("R4 no flag below thr", {32'b0, r}, 64'd0);
    sbe(2);
    rd(4'h4, r); check("R5 wrap to zero", {32'b0, r}, 64'd0);
    rd(4'h5, r); check("R5 sbe flag", {32'b0, r}, 64'd1);
    sbe(5);
    rd(4'h5, r); check("R8 repeat threshold", {32'b0, r}, 64'd5);

    // R9 clear and clear-vs-event
    wr(4'h5, 32'h7);
    rd(4'h5, r); check("R9 clear all", {32'b0, r}, 64'd0);
    cyc(1, 4'h5, 32'h7, 0, 1, 64'h0);
    rd(4'h5, r); check("R9 event ignored on clear", {32'b0, r}, 64'd0);

    // R7/R8/R11 multi-bit
    cyc(0, 4'h0, 0, 0, 1, 64'hDEAD_0001_BEEF_0002);
    rd(4'h5, r); check("R7 mbe flag", {32'b0, r}, 64'd2);
    rd(4'h8, r); check("R11 kind mbe", {32'b0, r}, 64'd2);
    rd(4'h6, r); check("R11 cap hi", {32'b0, r}, 64'hDEAD_0001);
    cyc(0, 4'h0, 0, 0, 1, 64'h0);
    rd(4'h5, r); check("R8 repeat mbe", {32'b0, r}, 64'd6);
    cyc(0, 4'h0, 0, 1, 1, 64'h1111_2222_3333_4444);
    rd(4'h8, r); check("R11 both -> mbe", {32'b0, r}, 64'd2);
    rd(4'h7, r); check("R11 cap lo both", {32'b0, r}, 64'h3333_4444);
    cyc(0, 4'h0, 0, 1, 0, 64'h5555_6666_7777_8888);
    rd(4'h8, r); check("R11 kind sbe", {32'b0, r}, 64'd1);
    rd(4'h7, r); check("R11 cap lo sbe", {32'b0, r}, 64'h7777_8888);

    // R6/R10 zero threshold, direct count load
    wr(4'h5, 32'h7);
    wr(4'h3, 32'd0);
    wr(4'h4, 32'd253);
    rd(4'h4, r); check("R10 count load", {32'b0, r}, 64'd253);
    sbe(4);
    rd(4'h4, r); check("R6 saturate", {32'b0, r}, 64'd255);
    rd(4'h5, r); check("R6 no flag", {32'b0, r}, 64'd0);
    cyc(1, 4'h4, 32'd10, 1, 0, 64'h0);
    rd(4'h4, r); check("R10 write beats report", {32'b0, r}, 64'd10);

    // R10 write beating the report that would reach the threshold
    wr(4'h3, 32'd11);
    cyc(1, 4'h4, 32'd10, 1, 0, 64'h0);
    rd(4'h5, r); check("R10 no threshold on write", {32'b0, r}, 64'd0);
    sbe(1);
    rd(4'h5, r); check("R5 hit after write", {32'b0, r}, 64'd1);

    repeat (2) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule